// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This block is a purely combinational 64-bit adder/subtractor for tagged integers, where the two least significant bits of each operand hold a type tag. It returns the sum or the difference. It also returns two sets of condition flags: one for the low 32-bit word and one for the full 64-bit word.

The 32-bit overflow flag is widened into a tag check. It is set when either operand carries a nonzero tag, and also when the 32-bit signed result overflows.

When the trap select is high, that combined condition raises a tag fault. The same condition raises a writeback-inhibit strobe, so the surrounding pipeline can discard the result and the flags. Register files, trap vectoring and writeback gating live outside the block.

Top module: `tagged_addsub`

## Requirements
- R1: With `doSub` low, `result` equals `opA + opB` modulo 2^64.
- R2: With `doSub` high, `result` equals `opA - opB` modulo 2^64, formed as `opA + ~opB + 1`.
- R3: Each flag nibble is ordered bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. The word flags (`wordFlags`) take N from `result[31]` and set Z when `result[31:0]` is zero. The long flags (`longFlags`) take N from `result[63]` and set Z when the whole result is zero.
- R4: For an add, C is the carry out of bit 31 (word) or bit 63 (long). For a subtract, C is the borrow: it is set when the unsigned minuend slice is below the subtrahend slice.
- R5: Long V is set exactly when the 64-bit signed add or subtract overflows.
- R6: Word V is set when `opA[1:0]` is nonzero, when `opB[1:0]` is nonzero, or when the 32-bit signed add or subtract of the low words overflows.
- R7: `tagFault` is high exactly when `trapOnTag` is high and word V is set.
- R8: `wbInhibit` is high exactly when `tagFault` is high. With `trapOnTag` low, neither output is ever raised, and `result` and both flag nibbles are still produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First operand; bits 1:0 are its tag |
| opB | input | 64 | Second operand; bits 1:0 are its tag |
| doSub | input | 1 | 0 = add, 1 = subtract |
| trapOnTag | input | 1 | Enables the tag-overflow fault |
| result | output | 64 | Sum or difference |
| wordFlags | output | 4 | N, Z, V, C for the low 32-bit word (V includes the tag check) |
| longFlags | output | 4 | N, Z, V, C for the full 64-bit word |
| tagFault | output | 1 | Tag-overflow fault |
| wbInhibit | output | 1 | Tells the pipeline not to commit the result or the flags |

## Verification
The block holds no state, so any internal fault shows at the ports in the same evaluation as the inputs that expose it.

A wrong carry split between the halves corrupts the upper result word and the long carry only for operands whose low words carry out. A mis-inverted subtrahend flips C and V for subtract only.

The sweep therefore pairs operands that sit on the sign, carry and tag boundaries of both word widths. It runs them under add and subtract, with and without the trap select, and compares every output against two's-complement arithmetic computed independently.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;
  // flag nibble layout
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic invertB;   // feed ~opB into the adder
    logic carryIn;   // adder carry in
    logic borrowC;   // report C as borrow
  } aluStrobe_t;
endpackage

// File: rtl/tagalu_flaggen.sv
module tagalu_flaggen #(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] laneSum,
  input  logic              aMsb,
  input  logic              bEffMsb,
  input  logic              carryOut,
  input  logic              borrowMode,
  output logic [3:0]        flags
);
  import tagalu_pkg::*;

  logic signMatch;
  logic signFlip;

  always_comb begin
    signMatch = (aMsb == bEffMsb);
    signFlip  = (laneSum[LANE_W-1] != aMsb);
    flags         = '0;
    flags[FLAG_N] = laneSum[LANE_W-1];
    flags[FLAG_Z] = (laneSum == '0);
    flags[FLAG_V] = signMatch & signFlip;
    flags[FLAG_C] = carryOut ^ borrowMode;
  end
endmodule

// File: rtl/tagalu_dpath.sv
module tagalu_dpath #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic [DATA_W-1:0]      opA,
  input  logic [DATA_W-1:0]      opB,
  input  tagalu_pkg::aluStrobe_t strobe,
  output logic [DATA_W-1:0]      sum,
  output logic [3:0]             rawWordFlags,
  output logic [3:0]             rawLongFlags,
  output logic                   tagDirty
);
  localparam int HIGH_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] bEff;
  logic [WORD_W:0]   lowSum;
  logic [HIGH_W:0]   highSum;
  logic              carryLow;
  logic              carryHigh;

  always_comb begin
    bEff     = strobe.invertB ? ~opB : opB;
    lowSum   = {1'b0, opA[WORD_W-1:0]} + {1'b0, bEff[WORD_W-1:0]}
               + {{WORD_W{1'b0}}, strobe.carryIn};
    carryLow = lowSum[WORD_W];
    highSum  = {1'b0, opA[DATA_W-1:WORD_W]} + {1'b0, bEff[DATA_W-1:WORD_W]}
               + {{HIGH_W{1'b0}}, carryLow};
    carryHigh = highSum[HIGH_W];
    sum      = {highSum[HIGH_W-1:0], lowSum[WORD_W-1:0]};
    tagDirty = (opA[TAG_W-1:0] != '0) | (opB[TAG_W-1:0] != '0);
  end

  // one flag generator per lane width: 0 = word, 1 = long
  for (genvar laneIdx = 0; laneIdx < 2; laneIdx++) begin : g_lane
    localparam int LW = (laneIdx == 0) ? WORD_W : DATA_W;
    logic [3:0] laneFlags;
    tagalu_flaggen #(.LANE_W(LW)) u_flags (
      .laneSum    (sum[LW-1:0]),
      .aMsb       (opA[LW-1]),
      .bEffMsb    (bEff[LW-1]),
      .carryOut   ((laneIdx == 0) ? carryLow : carryHigh),
      .borrowMode (strobe.borrowC),
      .flags      (laneFlags)
    );
    if (laneIdx == 0) begin : g_word
      assign rawWordFlags = laneFlags;
    end else begin : g_long
      assign rawLongFlags = laneFlags;
    end
  end
endmodule

// File: rtl/tagalu_ctrl.sv
module tagalu_ctrl (
  input  logic                   doSub,
  input  logic                   trapOnTag,
  input  logic                   rawWordV,
  input  logic                   tagDirty,
  output tagalu_pkg::aluStrobe_t strobe,
  output logic                   tagOverflow,
  output logic                   tagFault,
  output logic                   wbInhibit
);
  always_comb begin
    strobe.invertB = doSub;
    strobe.carryIn = doSub;
    strobe.borrowC = doSub;
    tagOverflow    = rawWordV | tagDirty;
    tagFault       = trapOnTag & tagOverflow;
    wbInhibit      = tagFault;
  end
endmodule

// File: rtl/tagged_addsub.sv
module tagged_addsub #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 2
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              doSub,
  input  logic              trapOnTag,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        wordFlags,
  output logic [3:0]        longFlags,
  output logic              tagFault,
  output logic              wbInhibit
);
  import tagalu_pkg::*;

  aluStrobe_t strobe;
  logic [3:0] rawWordFlags;
  logic       tagDirty;
  logic       tagOverflow;

  tagalu_ctrl u_ctrl (
    .doSub       (doSub),
    .trapOnTag   (trapOnTag),
    .rawWordV    (rawWordFlags[FLAG_V]),
    .tagDirty    (tagDirty),
    .strobe      (strobe),
    .tagOverflow (tagOverflow),
    .tagFault    (tagFault),
    .wbInhibit   (wbInhibit)
  );

  tagalu_dpath #(.DATA_W(DATA_W), .WORD_W(WORD_W), .TAG_W(TAG_W)) u_dpath (
    .opA          (opA),
    .opB          (opB),
    .strobe       (strobe),
    .sum          (result),
    .rawWordFlags (rawWordFlags),
    .rawLongFlags (longFlags),
    .tagDirty     (tagDirty)
  );

  always_comb begin
    wordFlags         = rawWordFlags;
    wordFlags[FLAG_V] = tagOverflow;
  end
endmodule

// File: rtl/tagged_addsub_chk.sv
module tagged_addsub_chk #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 2
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              trapOnTag,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        wordFlags,
  input logic [3:0]        longFlags,
  input logic              tagFault,
  input logic              wbInhibit
);
  always_comb begin
    // R7: a fault needs the enable
    a_r7_fault_needs_enable: assert (!tagFault || trapOnTag);
    // R6: a dirty tag always sets word V
    a_r6_tag_sets_v: assert ((opA[TAG_W-1:0] == '0 && opB[TAG_W-1:0] == '0) || wordFlags[1]);
    // R8: inhibit tracks the fault
    a_r8_inhibit_tracks_fault: assert (wbInhibit == tagFault);
    // R3: a zero long result implies a zero low word
    a_r3_zero_nest: assert (!longFlags[2] || wordFlags[2]);
    // R3: sign flags follow result bits
    a_r3_sign_bits: assert (wordFlags[3] == result[WORD_W-1] && longFlags[3] == result[DATA_W-1]);
  end
endmodule

bind tagged_addsub tagged_addsub_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W), .TAG_W(TAG_W)) u_chk (
  .opA       (opA),
  .opB       (opB),
  .trapOnTag (trapOnTag),
  .result    (result),
  .wordFlags (wordFlags),
  .longFlags (longFlags),
  .tagFault  (tagFault),
  .wbInhibit (wbInhibit)
);

// File: tb/tagged_addsub_tb.sv
module tagged_addsub_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [63:0] opA, opB, result;
  logic        doSub, trapOnTag;
  logic [3:0]  wordFlags, longFlags;
  logic        tagFault, wbInhibit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  tagged_addsub u_dut (
    .opA(opA), .opB(opB), .doSub(doSub), .trapOnTag(trapOnTag),
    .result(result), .wordFlags(wordFlags), .longFlags(longFlags),
    .tagFault(tagFault), .wbInhibit(wbInhibit)
  );

  function automatic logic [63:0] pick(input int idx);
    case (idx)
      0:  return 64'h0;
      1:  return 64'h1;
      2:  return 64'h2;
      3:  return 64'h3;
      4:  return 64'h4;
      5:  return 64'h0000_0000_7FFF_FFFC;
      6:  return 64'h0000_0000_8000_0000;
      7:  return 64'h0000_0000_FFFF_FFFC;
      8:  return 64'h0000_0000_FFFF_FFFF;
      9:  return 64'h0000_0001_0000_0000;
      10: return 64'h7FFF_FFFF_FFFF_FFFC;
      11: return 64'h8000_0000_0000_0000;
      12: return 64'hFFFF_FFFF_FFFF_FFFC;
      13: return 64'hFFFF_FFFF_FFFF_FFFF;
      14: return 64'h1234_5678_9ABC_DEF0;
      default: return 64'h0000_0000_7FFF_FFFF;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h sub=%0b trap=%0b actual=%h expected=%h",
               req, opA, opB, doSub, trapOnTag, act, exp);
    end
  endtask

  task automatic runCase(input logic [63:0] a, input logic [63:0] b,
                         input logic s, input logic t);
    logic [63:0] expRes;
    logic signed [65:0] wideS, longS;
    logic [32:0] lowU;
    logic [64:0] fullU;
    logic wN, wZ, wV, wC, lN, lZ, lV, lC, tagBad, expFault;
    @(negedge clk);
    opA = a; opB = b; doSub = s; trapOnTag = t;
    #1;
    if (!s) begin
      expRes = a + b;                                   // R1
      lowU   = {1'b0, a[31:0]} + {1'b0, b[31:0]};
      fullU  = {1'b0, a} + {1'b0, b};
      wC = lowU[32]; lC = fullU[64];                    // R4 carry
      wideS = $signed({{34{a[31]}}, a[31:0]}) + $signed({{34{b[31]}}, b[31:0]});
      longS = $signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b});
    end else begin
      expRes = a - b;                                   // R2
      wC = (a[31:0] < b[31:0]); lC = (a < b);           // R4 borrow
      wideS = $signed({{34{a[31]}}, a[31:0]}) - $signed({{34{b[31]}}, b[31:0]});
      longS = $signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b});
    end
    wV = (wideS > 66'sd2147483647) || (wideS < -66'sd2147483648);
    lV = (longS[65:63] != 3'b000) && (longS[65:63] != 3'b111);   // R5
    wN = expRes[31]; wZ = (expRes[31:0] == 0);
    lN = expRes[63]; lZ = (expRes == 0);
    tagBad   = (a[1:0] != 0) || (b[1:0] != 0);
    expFault = t && (tagBad || wV);
    check(s ? "R2" : "R1", result, expRes);
    check("R3", {62'd0, wordFlags[3:2]}, {62'd0, wN, wZ});
    check("R3", {62'd0, longFlags[3:2]}, {62'd0, lN, lZ});
    check("R4", {62'd0, wordFlags[0], longFlags[0]}, {62'd0, wC, lC});
    check("R5", {63'd0, longFlags[1]}, {63'd0, lV});
    check("R6", {63'd0, wordFlags[1]}, {63'd0, tagBad || wV});
    check("R7", {63'd0, tagFault}, {63'd0, expFault});
    check("R8", {63'd0, wbInhibit}, {63'd0, expFault});
  endtask

  initial begin
    opA = '0; opB = '0; doSub = 1'b0; trapOnTag = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state: zero inputs give a zero result with Z set
    @(negedge clk); #1;
    check("R3", {56'd0, wordFlags, longFlags}, {56'd0, 4'b0100, 4'b0100});
    check("R8", {63'd0, wbInhibit}, 64'd0);
    // R1 R2 R4 R5 R6 R7 R8 exhaustive over the boundary operand set
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 16; j++)
            runCase(pick(i), pick(j), s[0], t[0]);
    // R8: trap disabled leaves result intact even with dirty tags
    runCase(64'h3, 64'h1, 1'b0, 1'b0);
    check("R8", result, 64'h4);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule